// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit collects the five interrupt causes of a serial port: a receive line error, received data available, a character timeout, an empty transmit holding register and a modem-status change. It merges them into one interrupt request and an 8-bit identification value that software reads to learn which cause to service first. Each cause has an enable bit. Each cause is retired by its own side effect: reading the line status, reading received data, reading modem status, writing transmit data, or reading the identification value itself.

The receiver, the transmitter, the FIFOs and the register file sit outside this unit. They supply status levels, one-cycle event pulses, a 16x bit-clock tick and one-cycle access strobes. An interrupt-gate bit from the modem control register decides whether a pending cause reaches the interrupt pin. The character-timeout counter is built only when `HAS_TIMEOUT` is set. Its length is `TIMEOUT_CHARS * CHAR_BITS * OVERSAMPLE` ticks.

Top module: `uart_irq_ident`

## Requirements
- R1: `ident_o[0]` is 1 when no enabled cause is pending and 0 when at least one is. While it is 1, `ident_o[3:1]` is 000. After reset, with FIFO mode off, `ident_o` is 8'h01 and `irq_o` is 0.
- R2: `ident_o[3:1]` holds the code of the highest-ranked pending enabled cause. The ranking, from highest to lowest, is: line error 011, received data 010, character timeout 100, transmit holding register empty 001, modem change 000.
- R3: `ident_o[7:6]` is 11 when `fifo_en_i` is 1 and 00 when it is 0. `ident_o[5:4]` is always 00.
- R4: `int_en_i` bit 0 enables the received-data and timeout causes, bit 1 the transmit-empty cause, bit 2 the line-error cause and bit 3 the modem-change cause. A cause whose enable is 0 is not reported, but its latched state is kept.
- R5: A `line_err_i` pulse latches the line-error cause. A `rd_linestat_i` strobe clears it from the next cycle. If a new pulse arrives in the same cycle as the strobe, the cause stays set.
- R6: A `modem_chg_i` pulse latches the modem-change cause. A `rd_modemstat_i` strobe clears it from the next cycle, and a pulse in the same cycle wins.
- R7: The transmit-empty cause is set in the cycle after `txhold_empty_i` rises. It is also set in the cycle after `int_en_i[1]` rises while `txhold_empty_i` is 1. Reset treats the holding register as already empty, so reset alone sets nothing.
- R8: The transmit-empty cause clears after a `wr_txdata_i` strobe. It also clears after a `rd_ident_i` strobe, but only if `ident_o` read 8'bxx000010 in that same cycle. An identification read that shows any other code leaves it pending.
- R9: The received-data cause follows the `rx_ready_i` level in the same cycle, with no latching.
- R10: With `fifo_en_i` and `rx_nonempty_i` both 1, the timeout cause rises on the `TIMEOUT_CHARS*CHAR_BITS*OVERSAMPLE`-th `rx_tick_i` with no `rd_rxdata_i`. A `rd_rxdata_i` strobe clears it and restarts the count. Leaving FIFO mode or an empty receive FIFO also clears it.
- R11: `irq_o` is 1 exactly when a cause is pending (`ident_o[0]` is 0) and `irq_gate_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en_i | input | 4 | Per-cause enable bits (see R4) |
| fifo_en_i | input | 1 | FIFO mode is enabled |
| irq_gate_i | input | 1 | Interrupt output gate from modem control |
| rx_ready_i | input | 1 | Received data available (level) |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one character |
| rx_tick_i | input | 1 | 16x bit-clock enable |
| line_err_i | input | 1 | Receive line error detected (pulse) |
| modem_chg_i | input | 1 | Modem status input changed (pulse) |
| txhold_empty_i | input | 1 | Transmit holding register is empty (level) |
| rd_rxdata_i | input | 1 | Received data register read strobe |
| rd_linestat_i | input | 1 | Line status register read strobe |
| rd_modemstat_i | input | 1 | Modem status register read strobe |
| rd_ident_i | input | 1 | Identification register read strobe |
| wr_txdata_i | input | 1 | Transmit data register write strobe |
| ident_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `CHAR_BITS=10`, `OVERSAMPLE=2`, `TIMEOUT_CHARS=2` and `HAS_TIMEOUT=1`, with the tick held high. The timeout then expires after 40 clocks. This makes it cheap to check both sides of the expiry edge, an expiry after a read in mid-count restarts the count, and clearing by leaving FIFO mode. With these values every cause and every clearing path can be crossed with the others in a few hundred cycles. A behavioural model predicts `ident_o` and `irq_o` on every clock.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
   typedef enum logic [2:0] {
      IC_MODEM   = 3'b000,
      IC_TXEMPTY = 3'b001,
      IC_RXDATA  = 3'b010,
      IC_LINE    = 3'b011,
      IC_TMO     = 3'b100
   } uirq_code_e;

   localparam int unsigned EN_RXDATA  = 0;
   localparam int unsigned EN_TXEMPTY = 1;
   localparam int unsigned EN_LINE    = 2;
   localparam int unsigned EN_MODEM   = 3;
   localparam int unsigned EN_W       = 4;

   typedef struct packed {
      logic line;
      logic rxdata;
      logic tmo;
      logic txempty;
      logic modem;
   } uirq_src_t;
endpackage

// File: rtl/uirq_evt_latch.sv
`timescale 1ns/1ps
module uirq_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     pend_o <= 1'b0;
      else if (set_i) pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
   end
endmodule

// File: rtl/uirq_txempty_ctl.sv
`timescale 1ns/1ps
module uirq_txempty_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic empty_i,
   input  logic en_i,
   input  logic wr_i,
   input  logic ident_hit_i,
   output logic pend_o
);
   logic empty_q;
   logic en_q;
   logic set_w;

   // a fresh empty edge, or the enable opening onto an already empty register
   assign set_w = empty_i & (~empty_q | (en_i & ~en_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
         pend_o  <= 1'b0;
      end else begin
         empty_q <= empty_i;
         en_q    <= en_i;
         if (set_w)                    pend_o <= 1'b1;
         else if (wr_i || ident_hit_i) pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/uirq_tmo_timer.sv
`timescale 1ns/1ps
module uirq_tmo_timer #(
   parameter int unsigned TICKS = 640
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic restart_i,
   input  logic tick_i,
   output logic flag_o
);
   localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_o <= 1'b0;
      end else if (!arm_i || restart_i) begin
         cnt_q  <= '0;
         flag_o <= 1'b0;
      end else if (tick_i && !flag_o) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            flag_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uirq_prio_enc.sv
`timescale 1ns/1ps
module uirq_prio_enc
   import uirq_pkg::*;
(
   input  uirq_src_t  src_i,
   output uirq_code_e code_o,
   output logic       pend_o
);
   always_comb begin
      pend_o = |src_i;
      if (src_i.line)         code_o = IC_LINE;
      else if (src_i.rxdata)  code_o = IC_RXDATA;
      else if (src_i.tmo)     code_o = IC_TMO;
      else if (src_i.txempty) code_o = IC_TXEMPTY;
      else                    code_o = IC_MODEM;
   end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
   import uirq_pkg::*;
#(
   parameter int unsigned CHAR_BITS     = 10,
   parameter int unsigned OVERSAMPLE    = 16,
   parameter int unsigned TIMEOUT_CHARS = 4,
   parameter bit          HAS_TIMEOUT   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EN_W-1:0] int_en_i,
   input  logic            fifo_en_i,
   input  logic            irq_gate_i,
   input  logic            rx_ready_i,
   input  logic            rx_nonempty_i,
   input  logic            rx_tick_i,
   input  logic            line_err_i,
   input  logic            modem_chg_i,
   input  logic            txhold_empty_i,
   input  logic            rd_rxdata_i,
   input  logic            rd_linestat_i,
   input  logic            rd_modemstat_i,
   input  logic            rd_ident_i,
   input  logic            wr_txdata_i,
   output logic [7:0]      ident_o,
   output logic            irq_o
);
   localparam int unsigned TMO_TICKS = TIMEOUT_CHARS * CHAR_BITS * OVERSAMPLE;

   if (CHAR_BITS < 2) begin : g_bad_char
      $error("uart_irq_ident: CHAR_BITS must be at least 2");
   end
   if (OVERSAMPLE < 1) begin : g_bad_os
      $error("uart_irq_ident: OVERSAMPLE must be at least 1");
   end
   if (TIMEOUT_CHARS < 1) begin : g_bad_tc
      $error("uart_irq_ident: TIMEOUT_CHARS must be at least 1");
   end

   logic       line_pend;
   logic       modem_pend;
   logic       txe_pend;
   logic       tmo_flag;
   logic       any_pend;
   logic       ident_hit;
   uirq_src_t  src;
   uirq_code_e code;

   uirq_evt_latch u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (line_err_i),
      .clr_i  (rd_linestat_i),
      .pend_o (line_pend)
   );

   uirq_evt_latch u_modem (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (modem_chg_i),
      .clr_i  (rd_modemstat_i),
      .pend_o (modem_pend)
   );

   // identification read retires the transmit-empty cause only when it is the one shown
   assign ident_hit = rd_ident_i & any_pend & (code == IC_TXEMPTY);

   uirq_txempty_ctl u_txe (
      .clk         (clk),
      .rst_n       (rst_n),
      .empty_i     (txhold_empty_i),
      .en_i        (int_en_i[EN_TXEMPTY]),
      .wr_i        (wr_txdata_i),
      .ident_hit_i (ident_hit),
      .pend_o      (txe_pend)
   );

   if (HAS_TIMEOUT) begin : g_tmo
      uirq_tmo_timer #(.TICKS(TMO_TICKS)) u_tmo (
         .clk       (clk),
         .rst_n     (rst_n),
         .arm_i     (fifo_en_i & rx_nonempty_i),
         .restart_i (rd_rxdata_i),
         .tick_i    (rx_tick_i),
         .flag_o    (tmo_flag)
      );
   end else begin : g_no_tmo
      assign tmo_flag = 1'b0;
   end

   always_comb begin
      src.line    = int_en_i[EN_LINE]    & line_pend;
      src.rxdata  = int_en_i[EN_RXDATA]  & rx_ready_i;
      src.tmo     = int_en_i[EN_RXDATA]  & tmo_flag;
      src.txempty = int_en_i[EN_TXEMPTY] & txe_pend;
      src.modem   = int_en_i[EN_MODEM]   & modem_pend;
   end

   uirq_prio_enc u_enc (
      .src_i  (src),
      .code_o (code),
      .pend_o (any_pend)
   );

   assign ident_o = {fifo_en_i, fifo_en_i, 2'b00, code, ~any_pend};
   assign irq_o   = any_pend & irq_gate_i;
endmodule

// File: rtl/uirq_checker.sv
`timescale 1ns/1ps
module uirq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] int_en_i,
   input logic       fifo_en_i,
   input logic       irq_gate_i,
   input logic       rx_ready_i,
   input logic       line_err_i,
   input logic       modem_chg_i,
   input logic       txhold_empty_i,
   input logic       rd_linestat_i,
   input logic       rd_modemstat_i,
   input logic       wr_txdata_i,
   input logic [7:0] ident_o,
   input logic       irq_o
);
   // R1: a raised request implies the pending flag reads 0
   a_r1_pending_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !ident_o[0]);

   // R1: idle value carries code 000
   a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      ident_o[0] |-> (ident_o[3:1] == 3'b000));

   // R2: enabled received data is outranked only by a line error
   a_r2_rx_outranks: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en_i[0] && rx_ready_i) |->
         (!ident_o[0] && (ident_o[3:1] == 3'b011 || ident_o[3:1] == 3'b010)));

   // R3: mode bits track the FIFO flag, reserved bits stay zero
   a_r3_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en_i |-> (ident_o[7:4] == 4'b1100));
   a_r3_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en_i |-> (ident_o[7:4] == 4'b0000));

   // R5: a line status read with no new error removes code 011 next cycle
   a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_linestat_i && !line_err_i) |=> (ident_o[3:1] != 3'b011));

   // R6: a modem status read with no new change removes the modem cause
   a_r6_modem_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_modemstat_i && !modem_chg_i) |=> (ident_o[0] || ident_o[3:1] != 3'b000));

   // R8: a transmit write while not empty leaves no transmit-empty report
   a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txdata_i && !txhold_empty_i) |=> (ident_o[3:1] != 3'b001));

   // R11: the gate masks the request, and an open gate passes it
   a_r11_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_gate_i |-> !irq_o);
   a_r11_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_gate_i && !ident_o[0]) |-> irq_o);
endmodule

bind uart_irq_ident uirq_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .int_en_i       (int_en_i),
   .fifo_en_i      (fifo_en_i),
   .irq_gate_i     (irq_gate_i),
   .rx_ready_i     (rx_ready_i),
   .line_err_i     (line_err_i),
   .modem_chg_i    (modem_chg_i),
   .txhold_empty_i (txhold_empty_i),
   .rd_linestat_i  (rd_linestat_i),
   .rd_modemstat_i (rd_modemstat_i),
   .wr_txdata_i    (wr_txdata_i),
   .ident_o        (ident_o),
   .irq_o          (irq_o)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
   localparam int unsigned CB  = 10;
   localparam int unsigned OS  = 2;
   localparam int unsigned TC  = 2;
   localparam int          TMO = CB * OS * TC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] int_en = 4'h0;
   logic       fifo_en = 1'b0, gate = 1'b0, rx_ready = 1'b0, rx_nonempty = 1'b0;
   logic       tick = 1'b1, line_err = 1'b0, modem_chg = 1'b0, tx_empty = 1'b1;
   logic       rd_rx = 1'b0, rd_ls = 1'b0, rd_ms = 1'b0, rd_id = 1'b0, wr_tx = 1'b0;
   logic [7:0] ident;
   logic       irq;

   integer n_checks = 0;
   integer n_fail   = 0;

   always #10 clk = ~clk;

   uart_irq_ident #(
      .CHAR_BITS(CB), .OVERSAMPLE(OS), .TIMEOUT_CHARS(TC), .HAS_TIMEOUT(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .int_en_i(int_en), .fifo_en_i(fifo_en),
      .irq_gate_i(gate), .rx_ready_i(rx_ready), .rx_nonempty_i(rx_nonempty),
      .rx_tick_i(tick), .line_err_i(line_err), .modem_chg_i(modem_chg),
      .txhold_empty_i(tx_empty), .rd_rxdata_i(rd_rx), .rd_linestat_i(rd_ls),
      .rd_modemstat_i(rd_ms), .rd_ident_i(rd_id), .wr_txdata_i(wr_tx),
      .ident_o(ident), .irq_o(irq)
   );

   // ---------------- behavioural reference ----------------
   bit     m_ls, m_ms, m_th, m_to, m_prev_empty, m_prev_en;
   integer m_cnt;
   logic [7:0] m_cur;
   bit     m_set;

   function automatic logic [7:0] model_ident();
      logic [2:0] c;
      bit p;
      p = 1'b1;
      if (int_en[2] && m_ls)                c = 3'b011;
      else if (int_en[0] && rx_ready)       c = 3'b010;
      else if (int_en[0] && m_to)           c = 3'b100;
      else if (int_en[1] && m_th)           c = 3'b001;
      else if (int_en[3] && m_ms)           c = 3'b000;
      else begin c = 3'b000; p = 1'b0; end
      return {fifo_en, fifo_en, 2'b00, c, ~p};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ls = 0; m_ms = 0; m_th = 0; m_to = 0; m_cnt = 0;
         m_prev_empty = 1; m_prev_en = 0;
      end else begin
         m_cur = model_ident();
         m_set = tx_empty && (!m_prev_empty || (int_en[1] && !m_prev_en));
         if (m_set) m_th = 1;
         else if (wr_tx || (rd_id && m_cur[3:0] == 4'b0010)) m_th = 0;
         if (line_err) m_ls = 1; else if (rd_ls) m_ls = 0;
         if (modem_chg) m_ms = 1; else if (rd_ms) m_ms = 0;
         if (!(fifo_en && rx_nonempty) || rd_rx) begin
            m_cnt = 0; m_to = 0;
         end else if (tick && !m_to) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == TMO) begin m_to = 1; m_cnt = 0; end
         end
         m_prev_empty = tx_empty;
         m_prev_en    = int_en[1];
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [7:0] e;
         logic       ei;
         e  = model_ident();
         ei = !e[0] && gate;
         n_checks = n_checks + 1;
         if (ident !== e || irq !== ei) begin
            n_fail = n_fail + 1;
            if (ident[0] !== e[0])
               $display("FAIL R1 model: ident=%h irq=%b expected ident=%h irq=%b", ident, irq, e, ei);
            else if (ident[3:1] !== e[3:1])
               $display("FAIL R2 model: ident=%h irq=%b expected ident=%h irq=%b", ident, irq, e, ei);
            else if (ident[7:4] !== e[7:4])
               $display("FAIL R3 model: ident=%h irq=%b expected ident=%h irq=%b", ident, irq, e, ei);
            else
               $display("FAIL R11 model: ident=%h irq=%b expected ident=%h irq=%b", ident, irq, e, ei);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic expect_out(input logic [7:0] e_id, input logic e_irq, input string tag);
      @(negedge clk);
      n_checks = n_checks + 1;
      if (ident !== e_id || irq !== e_irq) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: ident=%h irq=%b expected ident=%h irq=%b", tag, ident, irq, e_id, e_irq);
      end
      cyc();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail = n_fail + 1;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      expect_out(8'h01, 1'b0, "R1 reset state");

      // R7: enable opening onto an empty holding register
      gate = 1'b1; int_en = 4'b0010; cyc();
      expect_out(8'h02, 1'b1, "R7 enable rise");
      // R8: identification read showing 001 retires it
      rd_id = 1'b1; cyc(); rd_id = 1'b0;
      expect_out(8'h01, 1'b0, "R8 ident read hit");
      // R7: empty transition
      tx_empty = 1'b0; cyc(); tx_empty = 1'b1; cyc();
      expect_out(8'h02, 1'b1, "R7 empty edge");
      // R11: gate closed
      gate = 1'b0; cyc();
      expect_out(8'h02, 1'b0, "R11 gate closed");
      gate = 1'b1;
      // R8: data write retires it
      tx_empty = 1'b0; wr_tx = 1'b1; cyc(); wr_tx = 1'b0;
      expect_out(8'h01, 1'b0, "R8 write clear");
      tx_empty = 1'b1; cyc();
      expect_out(8'h02, 1'b1, "R7 refill edge");

      // R2 ranking walk
      int_en = 4'b1111;
      modem_chg = 1'b1; cyc(); modem_chg = 1'b0;
      expect_out(8'h02, 1'b1, "R2 txempty over modem");
      line_err = 1'b1; cyc(); line_err = 1'b0;
      expect_out(8'h06, 1'b1, "R2 line on top");
      rx_ready = 1'b1;
      expect_out(8'h06, 1'b1, "R2 line over rxdata");
      rd_ls = 1'b1; cyc(); rd_ls = 1'b0;
      expect_out(8'h04, 1'b1, "R5 line read clear");
      rx_ready = 1'b0;
      expect_out(8'h02, 1'b1, "R9 rxdata level drop");
      tx_empty = 1'b0; wr_tx = 1'b1; cyc(); wr_tx = 1'b0;
      expect_out(8'h00, 1'b1, "R2 modem lowest");
      rd_ms = 1'b1; cyc(); rd_ms = 1'b0;
      expect_out(8'h01, 1'b0, "R6 modem read clear");

      // R8: identification read showing another code keeps transmit-empty
      tx_empty = 1'b1; cyc();
      rx_ready = 1'b1;
      rd_id = 1'b1; cyc(); rd_id = 1'b0; rx_ready = 1'b0;
      expect_out(8'h02, 1'b1, "R8 ident read miss");
      rd_id = 1'b1; cyc(); rd_id = 1'b0;
      expect_out(8'h01, 1'b0, "R8 ident read hit again");

      // R4: disabled cause hidden but kept
      int_en = 4'b1011;
      line_err = 1'b1; cyc(); line_err = 1'b0;
      expect_out(8'h01, 1'b0, "R4 line disabled");
      int_en = 4'b1111;
      expect_out(8'h06, 1'b1, "R4 line enabled shows latched");
      // R5: set wins over same-cycle read
      line_err = 1'b1; rd_ls = 1'b1; cyc(); line_err = 1'b0; rd_ls = 1'b0;
      expect_out(8'h06, 1'b1, "R5 set wins");
      rd_ls = 1'b1; cyc(); rd_ls = 1'b0;
      expect_out(8'h01, 1'b0, "R5 clear");

      // R3: FIFO mode bits
      fifo_en = 1'b1;
      expect_out(8'hC1, 1'b0, "R3 fifo bits");

      // R10: character timeout boundary
      rx_nonempty = 1'b1;
      repeat (TMO - 1) cyc();
      expect_out(8'hC1, 1'b0, "R10 one tick short");
      expect_out(8'hC8, 1'b1, "R10 expiry");
      rd_rx = 1'b1; cyc(); rd_rx = 1'b0;
      expect_out(8'hC1, 1'b0, "R10 read clears");
      repeat (20) cyc();
      rd_rx = 1'b1; cyc(); rd_rx = 1'b0;
      repeat (TMO - 1) cyc();
      expect_out(8'hC1, 1'b0, "R10 restart short");
      expect_out(8'hC8, 1'b1, "R10 restart expiry");
      fifo_en = 1'b0; cyc();
      expect_out(8'h01, 1'b0, "R10 leaving fifo clears");
      rx_nonempty = 1'b0;
      repeat (4) cyc();

      finish_run();
   end
endmodule